// File: doc/BRIEF.md
# Accumulator ALU with Status Flag Generation

This block is the arithmetic and logic datapath for a small 8-bit accumulator machine. Each cycle it takes the accumulator, a second operand, the current status flag byte and an operation selection. It computes a new 8-bit result and a new flag byte. The outputs are registered, so a result appears one clock after its inputs are presented. Register storage, memory traffic, instruction decode and timing of the surrounding machine belong to other blocks.

The operation is chosen by a 2-bit group code and a 3-bit select. Group 0 holds the eight two-operand operations: add, add with carry, subtract, subtract with borrow, AND, XOR, OR and compare. Group 1 holds single-operand increment and decrement of the second operand. Group 2 holds the accumulator-only operations: BCD adjust, bitwise complement, set carry and invert carry. The flag byte carries Zero at bit 7, Negative (last operation was a subtraction) at bit 6, Half carry at bit 5 and Carry at bit 4. Bits 3..0 of the flag output always read zero.

Top module: `alu8_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, `res_o` and `flags_o` become 0x00 on that edge.
- R2: Each result and flag byte appears on the outputs at the first rising edge after the inputs are applied, and holds until the next edge.
- R3: In group 0 (`grp_i`=0), select codes 0..7 are ADD, ADC, SUB, SBC, AND, XOR, OR, CP. ADD and ADC output the low 8 bits of acc+opnd(+carry-in), where carry-in is bit 4 of `flags_i` for ADC only; C is bit 8 of the 9-bit sum, H is the carry out of bit 3, N is 0, Z is 1 when the 8-bit result is zero.
- R4: SUB and SBC output the low 8 bits of acc-opnd(-carry-in), carry-in being bit 4 of `flags_i` for SBC only; C is 1 on a borrow out of bit 7, H is 1 on a borrow out of bit 3 including the carry-in, N is 1, Z reflects the result.
- R5: AND sets H and clears N and C; XOR and OR clear H, N and C; all three set Z from the result.
- R6: CP (select 7) produces the flags SUB would produce for the same inputs while `res_o` equals the accumulator.
- R7: Increment (`grp_i`=1, `sel_i[0]`=0) outputs opnd+1 modulo 256, clears N, sets H when the result's low nibble is zero, sets Z from the result and keeps C from `flags_i`.
- R8: Decrement (`grp_i`=1, `sel_i[0]`=1) outputs opnd-1 modulo 256, sets N, sets H when the operand's low nibble was zero, sets Z from the result and keeps C from `flags_i`.
- R9: BCD adjust (`grp_i`=2, `sel_i`=0): with N set, subtract 0x06 when H is set (kept to 8 bits), then subtract 0x60 when C is set; with N clear, add 0x06 when H is set or the low nibble exceeds 9, then add 0x60 when C is set or the value so far exceeds 0x9F. The result is the low 8 bits; H clears, N is kept, C stays set if it was set or else takes bit 8 of the adjusted value, Z reflects the result.
- R10: Complement (`grp_i`=2, `sel_i`=1) outputs the inverted accumulator, sets H and N and keeps Z and C. Set carry (`sel_i`=2) and invert carry (`sel_i`=3) output the accumulator, clear H and N, keep Z, and set C or toggle C respectively.
- R11: Group 2 with `sel_i` 4..7, and group 3 with any select, output the accumulator and `flags_i` with bits 3..0 cleared.
- R12: Bits 3..0 of `flags_o` are always zero, whatever `flags_i` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| grp_i | input | 2 | Operation group: 0 two-operand, 1 increment/decrement, 2 accumulator-only, 3 reserved |
| sel_i | input | 3 | Operation select within the group |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand |
| flags_i | input | 8 | Current flags: Z bit 7, N bit 6, H bit 5, C bit 4 |
| res_o | output | 8 | Registered result |
| flags_o | output | 8 | Registered new flags, bits 3..0 zero |

## Verification
The only state is the output register. A wrong value in it, such as a half carry taken from the wrong bit or a dropped carry-in, shows on `res_o` or `flags_o` one edge after the offending inputs and is gone on the next. So every operation is compared with a behavioural model in the cycle it lands. Decimal adjust is swept over every accumulator value and every N/H/C combination, because its errors hide in narrow value ranges. Increment and decrement are swept over every operand, and random operands cover the two-operand group.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DW    = 8;
    localparam int NIB   = 4;
    localparam int FW    = 4;
    localparam int SELW  = 3;
    localparam int GRPW  = 2;

    typedef enum logic [SELW-1:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBC = 3'd3,
        OP_AND = 3'd4,
        OP_XOR = 3'd5,
        OP_OR  = 3'd6,
        OP_CP  = 3'd7
    } alu_op_e;

    typedef enum logic [GRPW-1:0] {
        GRP_ALU  = 2'd0,
        GRP_STEP = 2'd1,
        GRP_ACC  = 2'd2,
        GRP_RSV  = 2'd3
    } grp_e;

    typedef enum logic [SELW-1:0] {
        ACC_BCD  = 3'd0,
        ACC_INV  = 3'd1,
        ACC_SETC = 3'd2,
        ACC_FLPC = 3'd3
    } acc_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic h;
        logic c;
    } flags_t;

    typedef struct packed {
        logic [DW-1:0] value;
        flags_t        fl;
    } alu_out_t;

    function automatic flags_t flags_from_byte(input logic [DW-1:0] b);
        flags_t f;
        f.z = b[DW-1];
        f.n = b[DW-2];
        f.h = b[DW-3];
        f.c = b[DW-4];
        return f;
    endfunction

    function automatic logic [DW-1:0] flags_to_byte(input flags_t f);
        return {f.z, f.n, f.h, f.c, {(DW-FW){1'b0}}};
    endfunction

    function automatic logic all_zero(input logic [DW-1:0] v);
        return (v == '0);
    endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int W = alu8_pkg::DW
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           c_in,
    output logic [W-1:0]   y,
    output flags_t         fl
);
    logic           use_c;
    logic [W:0]     cin_w;
    logic [W:0]     sum_w;
    logic [W:0]     dif_w;
    logic [NIB:0]   hsum;
    logic [NIB:0]   hdif;

    always_comb begin
        use_c = ((op == OP_ADC) || (op == OP_SBC)) ? c_in : 1'b0;
        cin_w = {{W{1'b0}}, use_c};
        sum_w = {1'b0, a} + {1'b0, b} + cin_w;
        dif_w = {1'b0, a} - {1'b0, b} - cin_w;
        hsum  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, use_c};
        hdif  = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - {{NIB{1'b0}}, use_c};
    end

    always_comb begin
        y  = a;
        fl = '0;
        unique case (op)
            OP_ADD, OP_ADC: begin
                y    = sum_w[W-1:0];
                fl.c = sum_w[W];
                fl.h = hsum[NIB];
                fl.n = 1'b0;
                fl.z = all_zero(sum_w[W-1:0]);
            end
            OP_SUB, OP_SBC, OP_CP: begin
                y    = (op == OP_CP) ? a : dif_w[W-1:0];
                fl.c = dif_w[W];
                fl.h = hdif[NIB];
                fl.n = 1'b1;
                fl.z = all_zero(dif_w[W-1:0]);
            end
            OP_AND: begin
                y    = a & b;
                fl.h = 1'b1;
                fl.z = all_zero(a & b);
            end
            OP_XOR: begin
                y    = a ^ b;
                fl.z = all_zero(a ^ b);
            end
            OP_OR: begin
                y    = a | b;
                fl.z = all_zero(a | b);
            end
            default: begin
                y  = a;
                fl = '0;
            end
        endcase
    end
endmodule

// File: rtl/alu8_step.sv
module alu8_step
    import alu8_pkg::*;
#(
    parameter int W = alu8_pkg::DW
) (
    input  logic           dec,
    input  logic [W-1:0]   b,
    input  logic           c_in,
    output logic [W-1:0]   y,
    output flags_t         fl
);
    logic [W-1:0] up;
    logic [W-1:0] down;

    always_comb begin
        up   = b + {{(W-1){1'b0}}, 1'b1};
        down = b - {{(W-1){1'b0}}, 1'b1};
        fl.c = c_in;
        if (dec) begin
            y    = down;
            fl.n = 1'b1;
            fl.h = (b[NIB-1:0] == '0);
            fl.z = all_zero(down);
        end else begin
            y    = up;
            fl.n = 1'b0;
            fl.h = (up[NIB-1:0] == '0);
            fl.z = all_zero(up);
        end
    end
endmodule

// File: rtl/alu8_accx.sv
module alu8_accx
    import alu8_pkg::*;
#(
    parameter int W = alu8_pkg::DW
) (
    input  logic [SELW-1:0] sel,
    input  logic [W-1:0]    a,
    input  flags_t          fin,
    output logic [W-1:0]    y,
    output flags_t          fl
);
    localparam int XW = W + 2;
    localparam logic [XW-1:0] LO_FIX  = XW'(6);
    localparam logic [XW-1:0] HI_FIX  = XW'(96);
    localparam logic [XW-1:0] HI_LIM  = XW'(159);
    localparam logic [NIB-1:0] DIG_MAX = NIB'(9);

    logic [XW-1:0] v1;
    logic [XW-1:0] v2;
    logic [W-1:0]  lo_sub;

    always_comb begin
        lo_sub = a - W'(6);
        if (fin.n) begin
            v1 = fin.h ? {2'b00, lo_sub} : {2'b00, a};
            v2 = fin.c ? (v1 - HI_FIX) : v1;
        end else begin
            v1 = (fin.h || (a[NIB-1:0] > DIG_MAX)) ? ({2'b00, a} + LO_FIX) : {2'b00, a};
            v2 = (fin.c || (v1 > HI_LIM)) ? (v1 + HI_FIX) : v1;
        end
    end

    always_comb begin
        y  = a;
        fl = fin;
        case (acc_op_e'(sel))
            ACC_BCD: begin
                y    = v2[W-1:0];
                fl.h = 1'b0;
                fl.c = fin.c | v2[W];
                fl.z = all_zero(v2[W-1:0]);
            end
            ACC_INV: begin
                y    = ~a;
                fl.h = 1'b1;
                fl.n = 1'b1;
            end
            ACC_SETC: begin
                fl.c = 1'b1;
                fl.h = 1'b0;
                fl.n = 1'b0;
            end
            ACC_FLPC: begin
                fl.c = ~fin.c;
                fl.h = 1'b0;
                fl.n = 1'b0;
            end
            default: begin
                y  = a;
                fl = fin;
            end
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [GRPW-1:0]  grp_i,
    input  logic [SELW-1:0]  sel_i,
    input  logic [DW-1:0]    acc_i,
    input  logic [DW-1:0]    opnd_i,
    input  logic [DW-1:0]    flags_i,
    output logic [DW-1:0]    res_o,
    output logic [DW-1:0]    flags_o
);
    flags_t       fin;
    alu_out_t     u_ar, u_st, u_ax, nxt;
    logic [DW-1:0] ar_y, st_y, ax_y;
    flags_t       ar_f, st_f, ax_f;
    logic [DW-1:0] res_q;
    flags_t       fl_q;

    assign fin = flags_from_byte(flags_i);

    alu8_arith #(.W(DW)) u_arith (
        .op   (alu_op_e'(sel_i)),
        .a    (acc_i),
        .b    (opnd_i),
        .c_in (fin.c),
        .y    (ar_y),
        .fl   (ar_f)
    );

    alu8_step #(.W(DW)) u_step (
        .dec  (sel_i[0]),
        .b    (opnd_i),
        .c_in (fin.c),
        .y    (st_y),
        .fl   (st_f)
    );

    alu8_accx #(.W(DW)) u_accx (
        .sel  (sel_i),
        .a    (acc_i),
        .fin  (fin),
        .y    (ax_y),
        .fl   (ax_f)
    );

    always_comb begin
        u_ar = '{value: ar_y, fl: ar_f};
        u_st = '{value: st_y, fl: st_f};
        u_ax = '{value: ax_y, fl: ax_f};
        unique case (grp_e'(grp_i))
            GRP_ALU:  nxt = u_ar;
            GRP_STEP: nxt = u_st;
            GRP_ACC:  nxt = u_ax;
            default:  nxt = '{value: acc_i, fl: fin};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            fl_q  <= '0;
        end else begin
            res_q <= nxt.value;
            fl_q  <= nxt.fl;
        end
    end

    assign res_o   = res_q;
    assign flags_o = flags_to_byte(fl_q);

    // R12: the low nibble of the flag byte never carries information
    p_low_nibble_zero_r12: assert property (@(posedge clk) disable iff (rst)
        flags_o[FW-1:0] == '0);

    // R6: compare leaves the accumulator on the result port
    p_cp_keeps_acc_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(grp_i) == GRP_ALU && $past(sel_i) == OP_CP)
        |-> (res_o == $past(acc_i)));

    // R7 / R8: increment and decrement carry C through
    p_step_keeps_c_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(grp_i) == GRP_STEP)
        |-> (flags_o[DW-4] == $past(flags_i[DW-4])));

    // R10: set carry forces C and clears H and N
    p_setc_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(grp_i) == GRP_ACC && $past(sel_i) == ACC_SETC)
        |-> (flags_o[DW-4] && !flags_o[DW-3] && !flags_o[DW-2]));

    // R5: logic operations never report a carry
    p_logic_no_carry_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(grp_i) == GRP_ALU && $past(sel_i) >= OP_AND && $past(sel_i) <= OP_OR)
        |-> (!flags_o[DW-4] && !flags_o[DW-2]));

    // R3: for results written back, Z agrees with the result
    p_zero_matches_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(grp_i) == GRP_ALU && $past(sel_i) != OP_CP)
        |-> (flags_o[DW-1] == (res_o == '0)));

    // R11: reserved group passes the accumulator through
    p_reserved_pass_r11: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(grp_i) == GRP_RSV)
        |-> (res_o == $past(acc_i)));
endmodule

// File: tb/tb_alu8_core.sv
`timescale 1ns/1ps
module tb_alu8_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] grp_i = '0;
    logic [2:0] sel_i = '0;
    logic [7:0] acc_i = '0;
    logic [7:0] opnd_i = '0;
    logic [7:0] flags_i = '0;
    logic [7:0] res_o;
    logic [7:0] flags_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    alu8_core dut (
        .clk(clk), .rst(rst), .grp_i(grp_i), .sel_i(sel_i),
        .acc_i(acc_i), .opnd_i(opnd_i), .flags_i(flags_i),
        .res_o(res_o), .flags_o(flags_o)
    );

    function automatic void model(input int g, input int s, input int a, input int b,
                                  input int f, output int r, output int fo);
        int z, n, h, c, cin, t, v;
        z = (f >> 7) & 1; n = (f >> 6) & 1; h = (f >> 5) & 1; c = (f >> 4) & 1;
        r = a;
        if (g == 0) begin
            cin = (s == 1 || s == 3) ? c : 0;
            case (s)
                0, 1: begin
                    t = a + b + cin; r = t & 255;
                    h = ((a & 15) + (b & 15) + cin) > 15 ? 1 : 0;
                    c = t > 255 ? 1 : 0; n = 0; z = (r == 0) ? 1 : 0;
                end
                2, 3, 7: begin
                    t = a - b - cin;
                    h = ((a & 15) - (b & 15) - cin) < 0 ? 1 : 0;
                    c = t < 0 ? 1 : 0; n = 1; z = ((t & 255) == 0) ? 1 : 0;
                    r = (s == 7) ? a : (t & 255);
                end
                4: begin r = a & b; h = 1; c = 0; n = 0; z = (r == 0) ? 1 : 0; end
                5: begin r = a ^ b; h = 0; c = 0; n = 0; z = (r == 0) ? 1 : 0; end
                default: begin r = a | b; h = 0; c = 0; n = 0; z = (r == 0) ? 1 : 0; end
            endcase
        end else if (g == 1) begin
            if ((s & 1) == 0) begin
                r = (b + 1) & 255; n = 0; h = ((r & 15) == 0) ? 1 : 0;
            end else begin
                r = (b + 255) & 255; n = 1; h = ((b & 15) == 0) ? 1 : 0;
            end
            z = (r == 0) ? 1 : 0;
        end else if (g == 2 && s < 4) begin
            case (s)
                0: begin
                    v = a;
                    if (n != 0) begin
                        if (h != 0) v = (v - 6) & 255;
                        if (c != 0) v = v - 96;
                    end else begin
                        if (h != 0 || (v & 15) > 9) v = v + 6;
                        if (c != 0 || v > 159) v = v + 96;
                    end
                    h = 0;
                    if (((v >> 8) & 1) != 0) c = 1;
                    r = v & 255; z = (r == 0) ? 1 : 0;
                end
                1: begin r = (~a) & 255; h = 1; n = 1; end
                2: begin c = 1; h = 0; n = 0; end
                default: begin c = 1 - c; h = 0; n = 0; end
            endcase
        end
        fo = (z << 7) | (n << 6) | (h << 5) | (c << 4);
    endfunction

    function automatic string tag_of(input int g, input int s);
        if (g == 0) begin
            if (s <= 1) return "R3";
            if (s <= 3) return "R4";
            if (s <= 6) return "R5";
            return "R6";
        end
        if (g == 1) return ((s & 1) == 0) ? "R7" : "R8";
        if (g == 2 && s == 0) return "R9";
        if (g == 2 && s < 4) return "R10";
        return "R11";
    endfunction

    task automatic check(input string tag, input int r_exp, input int f_exp);
        checks++;
        if (res_o !== r_exp[7:0] || flags_o !== f_exp[7:0]) begin
            errors++;
            $display("FAIL %s: res=%02h flags=%02h expected res=%02h flags=%02h",
                     tag, res_o, flags_o, r_exp[7:0], f_exp[7:0]);
        end
    endtask

    // called at a falling edge; result checked at the next falling edge
    task automatic run_op(input int g, input int s, input int a, input int b, input int f);
        int r, fo;
        grp_i = g[1:0]; sel_i = s[2:0]; acc_i = a[7:0]; opnd_i = b[7:0]; flags_i = f[7:0];
        model(g, s, a, b, f, r, fo);
        @(negedge clk);
        check(tag_of(g, s), r, fo);
        // R12: low flag nibble always zero
        checks++;
        if (flags_o[3:0] !== 4'h0) begin
            errors++;
            $display("FAIL R12: flags low nibble=%0h expected 0", flags_o[3:0]);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int r, fo;
        // R1: reset clears outputs even with busy inputs
        grp_i = 2'd0; sel_i = 3'd0; acc_i = 8'hFF; opnd_i = 8'h01; flags_i = 8'hFF;
        repeat (3) @(negedge clk);
        check("R1", 0, 0);
        rst = 1'b0;

        // R2: output changes only at the edge
        run_op(0, 0, 8'h12, 8'h34, 0);
        grp_i = 2'd0; sel_i = 3'd4; acc_i = 8'hF0; opnd_i = 8'h0F; flags_i = 8'h00;
        #5;
        check("R2", 8'h46, 8'h00);
        @(negedge clk);
        check("R2", 8'h00, 8'hA0);

        // directed corners
        run_op(0, 0, 8'hFF, 8'h01, 8'h00);   // R3 wrap: Z H C
        run_op(0, 1, 8'h0F, 8'h00, 8'h10);   // R3 half carry from carry-in
        run_op(0, 1, 8'hFF, 8'h00, 8'h1F);   // R3 carry-in wraps to zero
        run_op(0, 0, 8'h08, 8'h08, 8'h10);   // R3 carry-in ignored on ADD
        run_op(0, 2, 8'h00, 8'h01, 8'h00);   // R4 borrow
        run_op(0, 3, 8'h10, 8'h0F, 8'h10);   // R4 borrow-in gives zero
        run_op(0, 3, 8'h00, 8'h00, 8'h10);   // R4 borrow from carry-in only
        run_op(0, 4, 8'hAA, 8'h55, 8'hF0);   // R5 AND zero
        run_op(0, 5, 8'h5A, 8'h5A, 8'h30);   // R5 XOR zero
        run_op(0, 6, 8'h00, 8'h80, 8'hF0);   // R5 OR
        run_op(0, 7, 8'h42, 8'h42, 8'h00);   // R6 equal
        run_op(0, 7, 8'h10, 8'h20, 8'h00);   // R6 less
        run_op(1, 0, 8'h00, 8'hFF, 8'h10);   // R7 wrap keeps C
        run_op(1, 0, 8'h00, 8'h0F, 8'h00);   // R7 half
        run_op(1, 1, 8'h00, 8'h00, 8'h10);   // R8 wrap
        run_op(1, 1, 8'h00, 8'h01, 8'h00);   // R8 zero
        run_op(2, 0, 8'h9A, 8'h00, 8'h00);   // R9 0x9A -> 0x00 C
        run_op(2, 0, 8'h0F, 8'h00, 8'h40);   // R9 N set, no adjust
        run_op(2, 1, 8'h3C, 8'h00, 8'h90);   // R10 complement
        run_op(2, 2, 8'h3C, 8'h00, 8'h60);   // R10 set carry
        run_op(2, 3, 8'h3C, 8'h00, 8'h90);   // R10 flip carry
        run_op(2, 5, 8'h77, 8'h00, 8'hEF);   // R11 unused select
        run_op(3, 2, 8'h55, 8'h12, 8'hBF);   // R11 reserved group

        // R9: full BCD adjust sweep
        for (int f = 0; f < 16; f++)
            for (int a = 0; a < 256; a++)
                run_op(2, 0, a, 0, (f << 4) | (a & 15));

        // R7, R8: step sweep
        for (int b = 0; b < 256; b++) begin
            run_op(1, 0, b & 31, b, (b & 1) << 4);
            run_op(1, 1, b & 31, b, ((b >> 1) & 1) << 4 | 8'hE0);
        end

        // R3..R6, R10, R11 random
        for (int i = 0; i < 3000; i++) begin
            int g, s;
            g = (i % 7 == 0) ? 2 : ((i % 11 == 0) ? 3 : 0);
            s = $urandom_range(0, 7);
            run_op(g, s, $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255));
        end

        // R1: reset mid-run
        rst = 1'b1;
        grp_i = 2'd2; sel_i = 3'd1; acc_i = 8'h00;
        @(negedge clk);
        check("R1", 0, 0);
        rst = 1'b0;
        model(2, 1, 0, 0, 0, r, fo);
        flags_i = 8'h00;
        @(negedge clk);
        check("R10", r, fo);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule